// File: doc/BRIEF.md
# Dual-Standard FSK Tone Synthesizer

This block produces the transmit carrier of a 300 bps full-duplex frequency-shift-keyed modem. A 24-bit phase accumulator runs on the 3.579545 MHz master clock and advances by a tuning word every cycle. The tuning word is chosen from eight precomputed values, one for each combination of frequency plan, call direction and data bit. The top accumulator bits address a quarter-wave sine table, and the table output becomes a signed 8-bit sample. The accumulator's most significant bit is also brought out as a square-wave copy of the tone for test.

The serial data bit arrives with no bit clock at any rate from 0 to 300 bps. It therefore passes through a two-stage synchronizer, and so do the three control inputs. A change of data bit or direction only swaps the tuning word. The accumulator is never cleared, so the phase stays continuous across every frequency switch. While the active-low transmit request is released, both outputs are held at zero and the accumulator keeps running.

Top module: `fsk_tone_synth`

## Requirements
- R1: `txData` = 1 sends the mark tone and `txData` = 0 sends the space tone. The tone index is {bellPlan, originate, txData}.
- R2: With `bellPlan` = 0: originate uses mark 980 Hz and space 1180 Hz; answer uses mark 1650 Hz and space 1850 Hz.
- R3: With `bellPlan` = 1: originate uses mark 1270 Hz and space 1070 Hz; answer uses mark 2225 Hz and space 2025 Hz.
- R4: `originate` = 1 selects the originate tones and `originate` = 0 selects the answer tones.
- R5: While the synchronized `txReqN` is 1, `sineOut` is 0 and `squareOut` is 0.
- R6: Each tuning word is round(f * 2^24 / 3579545), so every synthesized tone is within 6 Hz of its nominal value.
- R7: The accumulator is never cleared after reset, whatever the data, direction or mute changes, so the phase is continuous.
- R8: Each input passes two synchronizer flops. A value present at clock edge n sets the accumulator step applied at edge n+2 and the output mute at edge n+2.
- R9: `sineOut` at edge n+1 is derived from the accumulator value A after edge n. The quadrant is q = A[23:22] and the index is k = A[21:16]. When q is odd, k is replaced by 63-k. The magnitude is round(127*sin((k+0.5)*pi/128)), and it is negated for q = 2 and q = 3.
- R10: `squareOut` at edge n+1 equals bit 23 of the accumulator after edge n, unless the block is muted.
- R11: During reset the accumulator is 0, the synchronizers read as muted with all other inputs at 0, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, nominally 3.579545 MHz |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | 1 | Serial data bit, 1 = mark, 0 = space, asynchronous |
| originate | input | 1 | 1 = originate tone pair, 0 = answer tone pair |
| bellPlan | input | 1 | 0 = V.21-style plan, 1 = Bell 103-style plan |
| txReqN | input | 1 | Active-low transmit request; high mutes the outputs |
| sineOut | output | 8 | Signed sine sample, two's complement |
| squareOut | output | 1 | Square-wave tone for test |

## Verification
All eight tone indices are swept with transmission enabled. This separates the mark and space tones, the two directions and the two plans, and every sample is compared with an arithmetic model of the accumulator and the sine formula. Counting square-wave edges over each sweep window gives a frequency check at the ports. A pattern in which the data bit toggles every few cycles shows whether the synchronizer latency and the tuning-word switch are exact. Mixed direction changes and mute windows show whether the phase runs on unbroken through frequency changes and silences.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic [2:0] toneSel;  // {plan, originate, data}
    logic       mute;
  } tone_cmd_t;

  // Nominal tone frequency in Hz for a tone index {plan, originate, data}
  function automatic int unsigned toneHz(input int unsigned sel);
    case (sel)
      0: toneHz = 1850;  // plan A answer space
      1: toneHz = 1650;  // plan A answer mark
      2: toneHz = 1180;  // plan A originate space
      3: toneHz = 980;   // plan A originate mark
      4: toneHz = 2025;  // plan B answer space
      5: toneHz = 2225;  // plan B answer mark
      6: toneHz = 1070;  // plan B originate space
      default: toneHz = 1270;  // plan B originate mark
    endcase
  endfunction

  // Rounded tuning word: freq * 2^phaseW / clkHz
  function automatic longint tuningWord(input int unsigned freq,
                                        input longint clkHz,
                                        input int phaseW);
    longint num;
    num = longint'(freq) << (phaseW + 1);
    tuningWord = (num + clkHz) / (2 * clkHz);
  endfunction

  // Sine on [0, pi/2] by odd power series
  function automatic real quarterSin(input real x);
    real x2;
    x2 = x * x;
    quarterSin = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0 *
                 (1.0 - x2 / 72.0 * (1.0 - x2 / 110.0)))));
  endfunction

  // Quarter-table magnitude entry k of 2^addrW, amplitude amp
  function automatic int tableMag(input int k, input int addrW, input int amp);
    real ang;
    ang = (real'(k) + 0.5) * 3.14159265358979 / real'(2 ** (addrW + 1));
    tableMag = $rtoi(real'(amp) * quarterSin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/fsk_tone_ctrl.sv
module fsk_tone_ctrl
  import fsk_tone_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txData,
  input  logic      originate,
  input  logic      bellPlan,
  input  logic      txReqN,
  output tone_cmd_t cmd
);

  localparam int NUM_IN = 4;
  // Reset value: request released (muted), all else zero
  localparam logic [NUM_IN-1:0] RESET_VAL = 4'b0001;

  logic [NUM_IN-1:0] syncChain [SYNC_STAGES];
  logic [NUM_IN-1:0] rawIn;

  assign rawIn = {bellPlan, originate, txData, txReqN};

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncChain[s] <= RESET_VAL;
        end else if (s == 0) begin
          syncChain[s] <= rawIn;
        end else begin
          syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  logic [NUM_IN-1:0] syncOut;
  assign syncOut = syncChain[SYNC_STAGES-1];

  always_comb begin
    cmd.toneSel = syncOut[3:1];
    cmd.mute    = syncOut[0];
  end

endmodule

// File: rtl/fsk_tone_datapath.sv
module fsk_tone_datapath
  import fsk_tone_pkg::*;
#(
  parameter longint CLK_HZ  = 3579545,
  parameter int     PHASE_W = 24,
  parameter int     SINE_W  = 8,
  parameter int     LUT_AW  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tone_cmd_t                cmd,
  output logic [PHASE_W-1:0]       phase,
  output logic signed [SINE_W-1:0] sineOut,
  output logic                     squareOut
);

  localparam int NUM_TONES = 8;
  localparam int LUT_DEPTH = 2 ** LUT_AW;
  localparam int AMP       = 2 ** (SINE_W - 1) - 1;
  localparam int QUAD_HI   = PHASE_W - 1;
  localparam int IDX_HI    = PHASE_W - 3;
  localparam int IDX_LO    = PHASE_W - 2 - LUT_AW;

  // Tuning words, one per tone index
  logic [PHASE_W-1:0] stepTab [NUM_TONES];
  genvar t;
  generate
    for (t = 0; t < NUM_TONES; t++) begin : gStep
      localparam longint TW = tuningWord(toneHz(t), CLK_HZ, PHASE_W);
      assign stepTab[t] = PHASE_W'(TW);
    end
  endgenerate

  // Quarter-wave magnitude table
  logic [SINE_W-2:0] quarterTab [LUT_DEPTH];
  genvar k;
  generate
    for (k = 0; k < LUT_DEPTH; k++) begin : gTab
      localparam int MAG = tableMag(k, LUT_AW, AMP);
      assign quarterTab[k] = (SINE_W-1)'(MAG);
    end
  endgenerate

  // Phase accumulator: never cleared outside reset
  logic [PHASE_W-1:0] step;
  assign step = stepTab[cmd.toneSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + step;
  end

  // Quadrant folding
  logic [1:0]        quad;
  logic [LUT_AW-1:0] rawIdx;
  logic [LUT_AW-1:0] foldIdx;
  logic [SINE_W-2:0] mag;
  logic signed [SINE_W-1:0] signedSample;

  always_comb begin
    quad    = phase[QUAD_HI -: 2];
    rawIdx  = phase[IDX_HI:IDX_LO];
    foldIdx = quad[0] ? ~rawIdx : rawIdx;
    mag     = quarterTab[foldIdx];
    signedSample = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sineOut   <= '0;
      squareOut <= 1'b0;
    end else if (cmd.mute) begin
      sineOut   <= '0;
      squareOut <= 1'b0;
    end else begin
      sineOut   <= signedSample;
      squareOut <= phase[QUAD_HI];
    end
  end

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
  import fsk_tone_pkg::*;
#(
  parameter longint CLK_HZ      = 3579545,
  parameter int     PHASE_W     = 24,
  parameter int     SINE_W      = 8,
  parameter int     LUT_AW      = 6,
  parameter int     SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     txData,
  input  logic                     originate,
  input  logic                     bellPlan,
  input  logic                     txReqN,
  output logic signed [SINE_W-1:0] sineOut,
  output logic                     squareOut
);

  tone_cmd_t          cmd;
  logic [PHASE_W-1:0] phase;

  fsk_tone_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .txData   (txData),
    .originate(originate),
    .bellPlan (bellPlan),
    .txReqN   (txReqN),
    .cmd      (cmd)
  );

  fsk_tone_datapath #(
    .CLK_HZ (CLK_HZ),
    .PHASE_W(PHASE_W),
    .SINE_W (SINE_W),
    .LUT_AW (LUT_AW)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .phase    (phase),
    .sineOut  (sineOut),
    .squareOut(squareOut)
  );

endmodule

// File: rtl/fsk_tone_checker.sv
module fsk_tone_checker
  import fsk_tone_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int SINE_W  = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input tone_cmd_t                cmd,
  input logic [PHASE_W-1:0]       phase,
  input logic signed [SINE_W-1:0] sineOut,
  input logic                     squareOut
);

  localparam logic signed [SINE_W-1:0] MOST_NEG = {1'b1, {(SINE_W-1){1'b0}}};

  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.mute |=> (sineOut == '0 && squareOut == 1'b0)) else $error("mute");  // R5

  AST_PHASE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (phase != $past(phase))) else $error("phase stall");  // R7

  AST_SQUARE_MSB: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.mute |=> (squareOut == $past(phase[PHASE_W-1]))) else $error("square");  // R10

  AST_SINE_POS: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.mute && !phase[PHASE_W-1]) |=> ($signed(sineOut) > 0)) else $error("sign+");  // R9

  AST_SINE_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.mute && phase[PHASE_W-1]) |=> ($signed(sineOut) < 0)) else $error("sign-");  // R9

  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
    sineOut != MOST_NEG) else $error("range");  // R9

endmodule

bind fsk_tone_synth fsk_tone_checker #(
  .PHASE_W(PHASE_W),
  .SINE_W (SINE_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmd      (cmd),
  .phase    (phase),
  .sineOut  (sineOut),
  .squareOut(squareOut)
);

// File: tb/tb_fsk_tone_synth.sv
`timescale 1ns/1ps
module tb_fsk_tone_synth;

  localparam real CLK_HZ_R = 3579545.0;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txData = 1'b0, originate = 1'b0, bellPlan = 1'b0, txReqN = 1'b1;
  logic signed [7:0] sineOut;
  logic squareOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit comparing = 0;
  string tag = "R11";

  always #10 clk = ~clk;

  fsk_tone_synth dut (
    .clk(clk), .rstN(rstN), .txData(txData), .originate(originate),
    .bellPlan(bellPlan), .txReqN(txReqN), .sineOut(sineOut), .squareOut(squareOut)
  );

  // Nominal frequencies indexed by {plan, originate, data}
  function automatic int nomHz(input int sel);
    int tbl [8] = '{1850, 1650, 1180, 980, 2025, 2225, 1070, 1270};
    return tbl[sel];
  endfunction

  function automatic longint stepOf(input int sel);
    return longint'($rtoi(real'(nomHz(sel)) * 16777216.0 / CLK_HZ_R + 0.5));
  endfunction

  function automatic int sineOf(input longint acc);
    int q, k, m;
    q = int'((acc >> 22) & 3);
    k = int'((acc >> 16) & 63);
    if (q % 2 == 1) k = 63 - k;
    m = $rtoi(127.0 * $sin((real'(k) + 0.5) * PI / 128.0) + 0.5);
    return (q >= 2) ? -m : m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: two sync stages, accumulator, output register
  logic [3:0] mS1, mS2;  // {plan, originate, data, reqN}
  longint mAcc;
  int mSine;
  bit mSq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 4'b0001; mS2 = 4'b0001; mAcc = 0; mSine = 0; mSq = 0;
    end else begin
      if (mS2[0]) begin
        mSine = 0; mSq = 0;
      end else begin
        mSine = sineOf(mAcc); mSq = mAcc[23];
      end
      mAcc = (mAcc + stepOf(int'(mS2[3:1]))) & 64'hFFFFFF;
      mS2 = mS1;
      mS1 = {bellPlan, originate, txData, txReqN};
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      check(int'(sineOut) == mSine, {tag, " R9 sine"}, int'(sineOut), mSine);
      check(squareOut == mSq, {tag, " R10 square"}, int'(squareOut), int'(mSq));
    end
  end

  // Square-wave rising edges for frequency check
  int edgeCount = 0;
  logic prevSq = 1'b0;
  always @(negedge clk) begin
    if (squareOut && !prevSq) edgeCount++;
    prevSq = squareOut;
  end

  task automatic setIn(input int sel, input bit reqN);
    bellPlan = sel[2]; originate = sel[1]; txData = sel[0]; txReqN = reqN;
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(sineOut == 0, "R11 reset sine", int'(sineOut), 0);
    check(squareOut == 0, "R11 reset square", int'(squareOut), 0);
    rstN = 1'b1;
    comparing = 1;

    // Sweep all tone indices: R1 R2 R3 R4 R6
    for (int sel = 0; sel < 8; sel++) begin
      int n;
      real expEdges;
      tag = sel[2] ? "R3 R1 R4" : "R2 R1 R4";
      setIn(sel, 1'b0);
      repeat (4) @(negedge clk);
      edgeCount = 0;
      n = 9000;
      repeat (n) @(negedge clk);
      expEdges = real'(nomHz(sel)) * real'(n) / CLK_HZ_R;
      check((real'(edgeCount) > expEdges - 1.5) && (real'(edgeCount) < expEdges + 1.5),
            "R6 tone frequency", edgeCount, $rtoi(expEdges + 0.5));
    end

    // R8: rapid data toggling exposes synchronizer latency
    tag = "R8";
    for (int i = 0; i < 400; i++) begin
      txData = ~txData;
      repeat (1 + (i % 4)) @(negedge clk);
    end

    // R7: direction and plan changes with mute windows, phase continuous
    tag = "R7";
    for (int i = 0; i < 24; i++) begin
      setIn((i * 5) % 8, 1'b0);
      repeat (200 + 13 * i) @(negedge clk);
      if (i % 3 == 0) begin
        tag = "R5";
        txReqN = 1'b1;
        repeat (300) @(negedge clk);
        check(sineOut == 0, "R5 muted sine", int'(sineOut), 0);
        check(squareOut == 0, "R5 muted square", int'(squareOut), 0);
        txReqN = 1'b0;
        tag = "R7";
      end
    end

    // R5: mute toggling right at the edge of the synchronizer
    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      txReqN = ~txReqN;
      repeat (1 + (i % 3)) @(negedge clk);
    end
    txReqN = 1'b0;
    repeat (50) @(negedge clk);

    comparing = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule